// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small memory-mapped bank of chip control registers on a simple 32-bit bus. The bus carries an address, write data and a write strobe, and returns read data combinationally. The bank drives a device-state control word, a mixed write-once/plain pin configuration word and an access-permission word into the rest of the chip. It also presents a read-only device status word and a silicon revision code.

Writes are guarded at two levels. First, the whole area stays closed until software writes two fixed keys, in order, to two unlock ("kick") locations. Second, the device-state control word only accepts writes while a companion lock word holds its own key value. The write-once bits of the pin configuration word keep the first value written after reset. A blocked write still completes on the bus and leaves the target unchanged.

Top module: `keyprot_cfg_bank`

## Requirements
- R1: After reset the area is closed, the permission word (0x41C) reads 0xAAAAAAAA, and the lock word (0x40004), control word (0x40008) and pin configuration word (0x40020) read 0.
- R2: Writing 0x83E70B13 to offset 0x38 and then 0x95A4F1E0 to offset 0x3C opens the area, and later writes to the protected words take effect on the next clock edge.
- R3: The area stays closed if the second key arrives before the first, if a wrong value is written to 0x38, or if only the first key has been written.
- R4: While the area is closed, writes to 0x41C, 0x40004, 0x40008 and 0x40020 leave their contents unchanged.
- R5: Writing any value other than its key to either unlock location closes an open area.
- R6: The control word at 0x40008 changes only if the lock word at 0x40004 holds 0x0F0A0B00 at the time of the write.
- R7: Bits of the pin configuration word selected by WO_MASK (default 0x000000FF) take the value of the first accepted write after reset and then never change; unselected bits follow every accepted write; reset clears the once-written state.
- R8: Offset 0x0 reads the dev_status_i input; offset 0x8 reads SILICON_REV in bits 31:28 with zeros elsewhere.
- R9: The unlock locations 0x38 and 0x3C read as zero, and unmapped offsets read zero and ignore writes.
- R10: Once the area is open, the permission word at 0x41C is freely readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dev_status_i | input | 32 | Device status sampled by reads of offset 0x0 |
| dev_ctl_o | output | 32 | Device-state control word |
| pin_cfg_o | output | 32 | Pin configuration word with write-once bits |
| perm_o | output | 32 | Access permission word |

## Verification
The hardest case to reach is the control word actually changing. That needs the area opened by both keys in order, then the lock word loaded with its key, and only then the control write. The stimulus table walks through this chain one step at a time, and it probes the partial states on the way: the second key before the first, only the first key, and a control write before the lock key. Write-once behaviour is checked with a second write that changes both masked and unmasked bits. A reset in the middle of the run then confirms that the area is closed again and that the once-written state has been cleared.

// File: rtl/keyprot_pkg.sv
// Package: shared constants and types of the key-protected register bank.
// Assumes byte offsets on a 20-bit address and 32-bit data words.
package keyprot_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 20;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 20'h00000;
    localparam logic [ADDR_W-1:0] OFS_REV    = 20'h00008;
    localparam logic [ADDR_W-1:0] OFS_KICK_A = 20'h00038;
    localparam logic [ADDR_W-1:0] OFS_KICK_B = 20'h0003C;
    localparam logic [ADDR_W-1:0] OFS_PERM   = 20'h0041C;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 20'h40004;
    localparam logic [ADDR_W-1:0] OFS_CTL    = 20'h40008;
    localparam logic [ADDR_W-1:0] OFS_PINCFG = 20'h40020;

    localparam logic [DATA_W-1:0] KICK_KEY_A = 32'h83E70B13;
    localparam logic [DATA_W-1:0] KICK_KEY_B = 32'h95A4F1E0;
    localparam logic [DATA_W-1:0] CTL_KEY    = 32'h0F0A0B00;
    localparam logic [DATA_W-1:0] PERM_RST   = 32'hAAAAAAAA;

    typedef enum logic [1:0] {
        KS_CLOSED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } kick_state_e;
endpackage

// File: rtl/kp_kick_fsm.sv
// Module: ordered two-key unlock sequencer for the whole register area.
// Assumes wr_a / wr_b are single-cycle write strobes to the two unlock words.
module kp_kick_fsm
    import keyprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic              area_open
);
    kick_state_e state_q;
    kick_state_e state_d;

    // Next-state: key A arms, key B after A opens, anything else closes.
    always_comb begin
        state_d = state_q;
        if (wr_a) begin
            state_d = (wdata == KICK_KEY_A) ? KS_HALF : KS_CLOSED;
        end else if (wr_b) begin
            if (wdata == KICK_KEY_B && state_q != KS_CLOSED) begin
                state_d = KS_OPEN;
            end else begin
                state_d = KS_CLOSED;
            end
        end
    end

    // State register, closed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_CLOSED;
        else        state_q <= state_d;
    end

    assign area_open = (state_q == KS_OPEN);

    // A wrong value on the first unlock word leaves the area closed.
    p_bad_key_a_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && wdata != KICK_KEY_A) |=> !area_open);

    // Opening only ever follows a correct key-B write.
    p_open_needs_key_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(area_open) |-> $past(wr_b && wdata == KICK_KEY_B));

    // Key B alone from closed never opens.
    p_b_first_stays_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !wr_a && state_q == KS_CLOSED) |=> !area_open);
endmodule

// File: rtl/kp_wonce_reg.sv
// Module: data register whose bits are individually plain or write-once.
// Assumes wr_en is already qualified by all access gates; a write-once bit
// takes the first accepted write after reset and is then frozen until reset.
module kp_wonce_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] WO_MASK = '0,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (WO_MASK[i]) begin : g_once
            logic done_q;
            // Capture the first accepted write, then set the sticky flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[i]   <= RST_VAL[i];
                    done_q <= 1'b0;
                end else if (wr_en && !done_q) begin
                    q[i]   <= wdata[i];
                    done_q <= 1'b1;
                end
            end

            // Once the flag is set the bit holds its value.
            p_frozen_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
                done_q |=> $stable(q[i]));
        end else begin : g_plain
            // Ordinary bit: follow every accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= RST_VAL[i];
                else if (wr_en) q[i] <= wdata[i];
            end
        end
    end
endmodule

// File: rtl/kp_rd_mux.sv
// Module: combinational read-data selector for the register bank.
// Assumes word-aligned offsets; unlock words and unmapped offsets return zero.
module kp_rd_mux
    import keyprot_pkg::*;
#(
    parameter logic [3:0] SILICON_REV = 4'h0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] perm,
    input  logic [DATA_W-1:0] lock_word,
    input  logic [DATA_W-1:0] ctl,
    input  logic [DATA_W-1:0] pincfg,
    output logic [DATA_W-1:0] rdata
);
    // Select the word addressed by the bus.
    always_comb begin
        unique case (addr)
            OFS_STATUS: rdata = status;
            OFS_REV:    rdata = {SILICON_REV, {(DATA_W-4){1'b0}}};
            OFS_PERM:   rdata = perm;
            OFS_LOCK:   rdata = lock_word;
            OFS_CTL:    rdata = ctl;
            OFS_PINCFG: rdata = pincfg;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/keyprot_cfg_bank.sv
// Module: top of the key-protected configuration register bank.
// Assumes one access per cycle: a write when bus_we is high, a combinational
// read of bus_addr otherwise. Blocked writes complete silently.
module keyprot_cfg_bank
    import keyprot_pkg::*;
#(
    parameter logic [3:0]        SILICON_REV = 4'h3,
    parameter logic [DATA_W-1:0] WO_MASK     = 32'h000000FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] dev_status_i,
    output logic [DATA_W-1:0] dev_ctl_o,
    output logic [DATA_W-1:0] pin_cfg_o,
    output logic [DATA_W-1:0] perm_o
);
    logic              area_open;
    logic              wr_perm, wr_lock, wr_ctl, wr_pin;
    logic [DATA_W-1:0] lock_q;

    // Unlock sequencer for the whole area.
    kp_kick_fsm u_kick (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (bus_we && bus_addr == OFS_KICK_A),
        .wr_b      (bus_we && bus_addr == OFS_KICK_B),
        .wdata     (bus_wdata),
        .area_open (area_open)
    );

    // Write qualification: area gate for all, plus the lock key for control.
    always_comb begin
        wr_perm = bus_we && area_open && bus_addr == OFS_PERM;
        wr_lock = bus_we && area_open && bus_addr == OFS_LOCK;
        wr_pin  = bus_we && area_open && bus_addr == OFS_PINCFG;
        wr_ctl  = bus_we && area_open && bus_addr == OFS_CTL && lock_q == CTL_KEY;
    end

    kp_wonce_reg #(.W(DATA_W), .WO_MASK('0), .RST_VAL(PERM_RST)) u_perm (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_perm), .wdata (bus_wdata), .q (perm_o)
    );

    kp_wonce_reg #(.W(DATA_W), .WO_MASK('0), .RST_VAL('0)) u_lock (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_lock), .wdata (bus_wdata), .q (lock_q)
    );

    kp_wonce_reg #(.W(DATA_W), .WO_MASK('0), .RST_VAL('0)) u_ctl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_ctl), .wdata (bus_wdata), .q (dev_ctl_o)
    );

    kp_wonce_reg #(.W(DATA_W), .WO_MASK(WO_MASK), .RST_VAL('0)) u_pin (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_pin), .wdata (bus_wdata), .q (pin_cfg_o)
    );

    kp_rd_mux #(.SILICON_REV(SILICON_REV)) u_rd (
        .addr      (bus_addr),
        .status    (dev_status_i),
        .perm      (perm_o),
        .lock_word (lock_q),
        .ctl       (dev_ctl_o),
        .pincfg    (pin_cfg_o),
        .rdata     (bus_rdata)
    );

    // Closed area: no protected word moves on any write.
    p_closed_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !area_open) |=> ($stable(perm_o) && $stable(lock_q)
                                    && $stable(dev_ctl_o) && $stable(pin_cfg_o)));

    // Control word is frozen unless the lock word holds its key.
    p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != CTL_KEY) |=> $stable(dev_ctl_o));

    // Writes to unmapped or read-only offsets change nothing.
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != OFS_PERM && bus_addr != OFS_LOCK
         && bus_addr != OFS_CTL && bus_addr != OFS_PINCFG)
        |=> ($stable(perm_o) && $stable(lock_q) && $stable(dev_ctl_o) && $stable(pin_cfg_o)));
endmodule

// File: tb/keyprot_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module keyprot_cfg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_status_i = 32'h12345678;
    logic [31:0] dev_ctl_o, pin_cfg_o, perm_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    keyprot_cfg_bank dut_i (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_rdata (bus_rdata), .dev_status_i (dev_status_i),
        .dev_ctl_o (dev_ctl_o), .pin_cfg_o (pin_cfg_o), .perm_o (perm_o)
    );

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 20'h00000, 32'h0, 32'h12345678, 4'd8},  // R8 status
        '{1'b0, 20'h00008, 32'h0, 32'h30000000, 4'd8},  // R8 revision
        '{1'b0, 20'h0041C, 32'h0, 32'hAAAAAAAA, 4'd1},  // R1 perm reset
        '{1'b1, 20'h0041C, 32'h11111111, 32'h0, 4'd4},
        '{1'b0, 20'h0041C, 32'h0, 32'hAAAAAAAA, 4'd4},  // R4 closed write
        '{1'b1, 20'h0003C, 32'h95A4F1E0, 32'h0, 4'd3},  // key B first
        '{1'b1, 20'h00038, 32'h83E70B13, 32'h0, 4'd2},
        '{1'b0, 20'h00038, 32'h0, 32'h0, 4'd9},          // R9 kick reads 0
        '{1'b1, 20'h0041C, 32'h22222222, 32'h0, 4'd3},
        '{1'b0, 20'h0041C, 32'h0, 32'hAAAAAAAA, 4'd3},  // R3 half open
        '{1'b1, 20'h0003C, 32'h95A4F1E0, 32'h0, 4'd2},
        '{1'b0, 20'h0003C, 32'h0, 32'h0, 4'd9},          // R9
        '{1'b1, 20'h0041C, 32'h33333333, 32'h0, 4'd10},
        '{1'b0, 20'h0041C, 32'h0, 32'h33333333, 4'd10}, // R10 / R2 open
        '{1'b1, 20'h40008, 32'h5, 32'h0, 4'd6},
        '{1'b0, 20'h40008, 32'h0, 32'h0, 4'd6},          // R6 no lock key
        '{1'b1, 20'h40004, 32'h0F0A0B00, 32'h0, 4'd6},
        '{1'b0, 20'h40004, 32'h0, 32'h0F0A0B00, 4'd6},
        '{1'b1, 20'h40008, 32'h5, 32'h0, 4'd6},
        '{1'b0, 20'h40008, 32'h0, 32'h5, 4'd6},          // R6 keyed
        '{1'b1, 20'h40004, 32'h1, 32'h0, 4'd6},
        '{1'b1, 20'h40008, 32'h7, 32'h0, 4'd6},
        '{1'b0, 20'h40008, 32'h0, 32'h5, 4'd6},          // R6 relocked
        '{1'b1, 20'h40020, 32'h0000A55A, 32'h0, 4'd7},
        '{1'b0, 20'h40020, 32'h0, 32'h0000A55A, 4'd7},
        '{1'b1, 20'h40020, 32'h00003C00, 32'h0, 4'd7},
        '{1'b0, 20'h40020, 32'h0, 32'h00003C5A, 4'd7},  // R7 low byte frozen
        '{1'b1, 20'h00038, 32'hDEAD0000, 32'h0, 4'd5},
        '{1'b1, 20'h0041C, 32'h44444444, 32'h0, 4'd5},
        '{1'b0, 20'h0041C, 32'h0, 32'h33333333, 4'd5},  // R5 relocked
        '{1'b1, 20'h00100, 32'hFFFFFFFF, 32'h0, 4'd9},
        '{1'b0, 20'h00100, 32'h0, 32'h0, 4'd9}           // R9 unmapped
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [19:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic open_area();
        wr(20'h00038, 32'h83E70B13);
        wr(20'h0003C, 32'h95A4F1E0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of every protected word
        rd_check(1, 20'h40004, 32'h0);
        rd_check(1, 20'h40008, 32'h0);
        rd_check(1, 20'h40020, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
            else           rd_check(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
        end

        // R3: wrong first key, then correct second key stays closed
        wr(20'h00038, 32'h83E70B12);
        wr(20'h0003C, 32'h95A4F1E0);
        wr(20'h0041C, 32'h55555555);
        rd_check(3, 20'h0041C, 32'h33333333);

        // R5: wrong value on second unlock word closes an open area
        open_area();
        wr(20'h0003C, 32'h00000001);
        wr(20'h0041C, 32'h66666666);
        rd_check(5, 20'h0041C, 32'h33333333);

        // R1: reset mid-run closes the area and restores reset values
        open_area();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd_check(1, 20'h0041C, 32'hAAAAAAAA);
        rd_check(1, 20'h40020, 32'h0);
        check(1, perm_o, 32'hAAAAAAAA);
        wr(20'h0041C, 32'h77777777);
        rd_check(1, 20'h0041C, 32'hAAAAAAAA);

        // R7: once-written state cleared by reset
        open_area();
        wr(20'h40020, 32'h000000FF);
        rd_check(7, 20'h40020, 32'h000000FF);
        check(7, pin_cfg_o, 32'h000000FF);

        // R8: status input followed live
        dev_status_i = 32'hCAFE0001;
        rd_check(8, 20'h00000, 32'hCAFE0001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule